// File: doc/BRIEF.md
# Radio Interrupt Mask and Status

This block sits between a radio transceiver core and the processor's interrupt controller. The transceiver produces eight single-cycle event pulses. Each pulse sets its own bit in a pending-status register, whatever the state of the enable mask. A second register, the enable mask, decides which pending bits raise their per-source interrupt request lines. The request lines are registered.

Software reaches both registers over a byte-wide register bus with read strobe, write strobe, address and data. Software retires a pending bit by writing a one to it. The interrupt controller can also retire a pending bit through a per-source acknowledge input, which it pulses when the service routine for that source starts. Events that arrive while their source is masked are still recorded. Software should therefore clear a source's stale pending bit before it enables that source.

Top module: `radio_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, the mask register, the status register and all request outputs are zero. A read of either register returns 0x00.
- R2: The bits have a fixed assignment, from bit 7 down to bit 0: wake-up, transmit done, address match, energy-detect done, receive done, receive start, PLL unlock, PLL lock. A pulse on `evt_i[i]` sets status bit i at the next clock edge, whatever the value of mask bit i.
- R3: A write to the status address clears every status bit whose write-data bit is 1. It leaves every bit whose write-data bit is 0 unchanged. Such a write never sets a status bit.
- R4: A pulse on `ack_i[i]` clears status bit i at the next clock edge.
- R5: If `evt_i[i]` is high in the same cycle as a write-one clear or an acknowledge of bit i, then status bit i is 1 after that edge.
- R6: The mask register is at address BASE_ADDR (default 0). The status register is at BASE_ADDR+1. Every bit of the mask register is written from the write data. A write to any other address changes nothing. A read of any other address returns 0x00, and `reg_rdata_o` is 0x00 while `reg_rd_i` is low.
- R7: In the cycle after the registered status and mask hold their values, `irq_o[i]` equals status bit i AND mask bit i.
- R8: During a cycle in which a register is updated, a read of that register returns the value it held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | Single-cycle event pulses from the transceiver, one per source |
| ack_i | input | 8 | Per-source service acknowledge from the interrupt controller |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from current state |
| irq_o | output | 8 | Registered per-source interrupt requests |

## Verification
The bench runs a full sweep over all 256 mask values. Each mask value is paired with an event pattern derived from it by arithmetic. This separates a wrong AND of status and mask, a missing register stage and a swapped bit from a correct design.

Single-bit walks exercise the behaviour that a full sweep hides:
- events while masked;
- write-zero against write-one;
- partial clears;
- acknowledge clears.

Directed collisions set an event against a write clear and against an acknowledge on the same bit and on a different bit. These tell the required event priority apart from a design where the clear wins. Reads issued in the same cycle as a write show whether read data reflects the state before or after the update.

// File: rtl/radio_irq_pkg.sv
package radio_irq_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ADDR_W  = 4;

  // fixed source bit positions
  typedef enum logic [2:0] {
    SRC_PLL_LOCK   = 3'd0,
    SRC_PLL_UNLOCK = 3'd1,
    SRC_RX_START   = 3'd2,
    SRC_RX_DONE    = 3'd3,
    SRC_ED_DONE    = 3'd4,
    SRC_ADDR_MATCH = 3'd5,
    SRC_TX_DONE    = 3'd6,
    SRC_WAKE       = 3'd7
  } irq_src_e;
endpackage

// File: rtl/radio_irq_regif.sv
module radio_irq_regif #(
  parameter int unsigned N         = 8,
  parameter int unsigned AW        = 4,
  parameter int unsigned BASE_ADDR = 0
) (
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [N-1:0]  mask_i,
  input  logic [N-1:0]  status_i,
  output logic          mask_we_o,
  output logic          stat_we_o,
  output logic [N-1:0]  rdata_o
);
  localparam logic [AW-1:0] MaskAddr = AW'(BASE_ADDR);
  localparam logic [AW-1:0] StatAddr = AW'(BASE_ADDR + 1);

  logic hit_mask, hit_stat;

  assign hit_mask  = (addr_i == MaskAddr);
  assign hit_stat  = (addr_i == StatAddr);
  assign mask_we_o = wr_i & hit_mask;
  assign stat_we_o = wr_i & hit_stat;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (hit_mask)      rdata_o = mask_i;
      else if (hit_stat) rdata_o = status_i;
    end
  end
endmodule

// File: rtl/radio_irq_mask.sv
module radio_irq_mask #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_o <= '0;
    else if (we_i) mask_o <= wdata_i;
  end
endmodule

// File: rtl/radio_irq_status.sv
module radio_irq_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] ack_i,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] status_o
);
  logic [N-1:0] clr;

  assign clr = (we_i ? wdata_i : '0) | ack_i;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         status_o[g] <= 1'b0;
      else if (evt_i[g])   status_o[g] <= 1'b1; // event beats clear
      else if (clr[g])     status_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/radio_irq_reqgen.sv
module radio_irq_reqgen #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] status_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= '0;
    else         irq_o <= status_i & mask_i;
  end
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl #(
  parameter int unsigned N         = radio_irq_pkg::NUM_SRC,
  parameter int unsigned AW        = radio_irq_pkg::ADDR_W,
  parameter int unsigned BASE_ADDR = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  evt_i,
  input  logic [N-1:0]  ack_i,
  input  logic          reg_wr_i,
  input  logic          reg_rd_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [N-1:0]  reg_wdata_i,
  output logic [N-1:0]  reg_rdata_o,
  output logic [N-1:0]  irq_o
);
  logic [N-1:0] mask_q, status_q;
  logic         mask_we, stat_we;

  radio_irq_regif #(.N(N), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_regif (
    .wr_i      (reg_wr_i),
    .rd_i      (reg_rd_i),
    .addr_i    (reg_addr_i),
    .mask_i    (mask_q),
    .status_i  (status_q),
    .mask_we_o (mask_we),
    .stat_we_o (stat_we),
    .rdata_o   (reg_rdata_o)
  );

  radio_irq_mask #(.N(N)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mask_we),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q)
  );

  radio_irq_status #(.N(N)) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .ack_i    (ack_i),
    .we_i     (stat_we),
    .wdata_i  (reg_wdata_i),
    .status_o (status_q)
  );

  radio_irq_reqgen #(.N(N)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );
endmodule

// File: rtl/radio_irq_ctrl_chk.sv
module radio_irq_ctrl_chk #(
  parameter int unsigned N         = 8,
  parameter int unsigned AW        = 4,
  parameter int unsigned BASE_ADDR = 0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [N-1:0]  evt_i,
  input logic [N-1:0]  ack_i,
  input logic          reg_wr_i,
  input logic [AW-1:0] reg_addr_i,
  input logic [N-1:0]  reg_wdata_i,
  input logic [N-1:0]  mask_q,
  input logic [N-1:0]  status_q,
  input logic [N-1:0]  irq_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_EVT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((status_q & $past(evt_i)) == $past(evt_i))); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0)); // R3

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ((status_q & $past(ack_i) & ~$past(evt_i)) == '0)); // R4

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(reg_wr_i) && ($past(reg_addr_i) == AW'(BASE_ADDR)))
      |-> (mask_q == $past(reg_wdata_i))); // R6

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (irq_o == $past(status_q & mask_q))); // R7
endmodule

bind radio_irq_ctrl radio_irq_ctrl_chk #(.N(N), .AW(AW), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_i       (evt_i),
  .ack_i       (ack_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .mask_q      (mask_q),
  .status_q    (status_q),
  .irq_o       (irq_o)
);

// File: tb/radio_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module radio_irq_ctrl_tb_top;
  localparam logic [3:0] A_MASK = 4'd0;
  localparam logic [3:0] A_STAT = 4'd1;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] evt_i = '0, ack_i = '0, reg_wdata_i = '0;
  logic       reg_wr_i = 1'b0, reg_rd_i = 1'b0;
  logic [3:0] reg_addr_i = '0;
  logic [7:0] reg_rdata_o, irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_mask = '0, m_stat = '0, m_irq = '0;

  always #4 clk_i = ~clk_i;

  radio_irq_ctrl dut_i (
    .clk_i, .rst_ni, .evt_i, .ack_i, .reg_wr_i, .reg_rd_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one clock cycle; read data sampled before the edge, model updated after
  task automatic step(input logic [7:0] evt, input logic [7:0] ack,
                      input logic wr, input logic rd, input logic [3:0] addr,
                      input logic [7:0] wd, input string rreq, input logic rchk);
    logic [7:0] exp_rd, clr;
    @(negedge clk_i);
    evt_i = evt; ack_i = ack; reg_wr_i = wr; reg_rd_i = rd;
    reg_addr_i = addr; reg_wdata_i = wd;
    #1;
    exp_rd = !rd ? 8'h00 : (addr == A_MASK) ? m_mask : (addr == A_STAT) ? m_stat : 8'h00;
    if (rchk) check(rreq, reg_rdata_o, exp_rd);
    @(posedge clk_i);
    m_irq = m_stat & m_mask;
    clr = ((wr && addr == A_STAT) ? wd : 8'h00) | ack;
    m_stat = (m_stat & ~clr) | evt;
    if (wr && addr == A_MASK) m_mask = wd;
    #1;
    evt_i = '0; ack_i = '0; reg_wr_i = 1'b0; reg_rd_i = 1'b0;
  endtask

  task automatic idle();
    step(8'h00, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
  endtask

  task automatic rd_chk(logic [3:0] a, string req);
    step(8'h00, 8'h00, 1'b0, 1'b1, a, 8'h00, req, 1'b1);
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    step(8'h00, 8'h00, 1'b1, 1'b0, a, d, "", 1'b0);
  endtask

  task automatic state_chk(string req);
    rd_chk(A_MASK, req);
    rd_chk(A_STAT, req);
    check(req, irq_o, m_irq);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #3;
    // R1 reset state
    check("R1 irq", irq_o, 8'h00);
    #20 rst_ni = 1'b1;
    state_chk("R1");
    check("R1 rd idle", reg_rdata_o, 8'h00);

    // R2: each source alone while masked sets its bit, no request
    for (int i = 0; i < 8; i++) begin
      step(8'(1 << i), 8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
      idle();
      check("R2 masked irq", irq_o, 8'h00);
      rd_chk(A_STAT, "R2 status");
      wr(A_STAT, 8'hFF);
    end

    // R3: write 0 keeps, write 1 clears partially, never sets
    step(8'hFF, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
    wr(A_STAT, 8'h00);
    rd_chk(A_STAT, "R3 write zero");
    wr(A_STAT, 8'h5A);
    rd_chk(A_STAT, "R3 partial clear");
    wr(A_STAT, 8'hFF);
    wr(A_STAT, 8'hFF);
    rd_chk(A_STAT, "R3 never sets");

    // R4: acknowledge clears per source
    step(8'hFF, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(8'h00, 8'(1 << i), 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
      rd_chk(A_STAT, "R4 ack");
    end

    // R5: event beats write clear and ack on the same bit
    step(8'h81, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
    step(8'h01, 8'h00, 1'b1, 1'b0, A_STAT, 8'h81, "", 1'b0);
    rd_chk(A_STAT, "R5 evt vs write");
    step(8'h01, 8'h01, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
    rd_chk(A_STAT, "R5 evt vs ack");
    step(8'h02, 8'h01, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
    rd_chk(A_STAT, "R5 evt other bit");
    wr(A_STAT, 8'hFF);

    // R6: decode, unmapped addresses, read strobe low
    wr(A_MASK, 8'hC3);
    rd_chk(A_MASK, "R6 mask rw");
    step(8'h00, 8'h00, 1'b0, 1'b0, A_MASK, 8'h00, "R6 rd low", 1'b1);
    for (int a = 2; a < 16; a++) begin
      wr(4'(a), 8'hFF);
      rd_chk(4'(a), "R6 unmapped read");
    end
    state_chk("R6 unmapped write");
    wr(A_MASK, 8'h00);

    // R7: sweep all mask values with derived event patterns
    for (int m = 0; m < 256; m++) begin
      logic [7:0] p;
      p = 8'((m * 37 + 11) & 8'hFF);
      wr(A_STAT, 8'hFF);
      wr(A_MASK, 8'(m));
      step(p, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
      check("R7 irq lag", irq_o, m_irq);
      idle();
      check("R7 irq", irq_o, 8'(m) & p);
    end

    // R8: same-cycle read and write return old value
    wr(A_MASK, 8'h0F);
    step(8'h00, 8'h00, 1'b1, 1'b1, A_MASK, 8'hF0, "R8 mask old", 1'b1);
    step(8'h30, 8'h00, 1'b0, 1'b0, 4'd0, 8'h00, "", 1'b0);
    step(8'h00, 8'h00, 1'b1, 1'b1, A_STAT, 8'h10, "R8 status old", 1'b1);
    state_chk("R8 after");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule